// File: doc/BRIEF.md
# Serial Configuration Memory Readout

This block is the read side of a one-bit-wide serial memory that another device clocks from outside. A bit-address counter selects one stored bit, which is presented on a serial data output. The host supplies a slow serial clock, an output-enable line that also acts as an active-low counter clear, and an active-low chip select. Each rising edge of the serial clock that arrives while the part is enabled and selected moves the counter to the next bit. The block reports the pad as a data value plus a separate drive-enable, so no internal tri-state is needed.

When the last stored bit has been clocked out, the block stops counting and pulls its active-low cascade output low. It also stops driving the data line. In a chain, that cascade output selects the next memory, which then drives the shared data line. A plain write port preloads the bit array, and a power-on reset clears the counter.

The serial clock is sampled in the block's own clock domain and is assumed to be slower than that clock. A rising edge is detected when the sampled level goes from low to high.

Top module: `scr_reader`

## Requirements
- R1: After power-on reset the counter points at bit 0, the cascade output is high, and the first stored bit is presented as soon as the part is enabled and selected.
- R2: Output enable low clears the counter to bit 0 and clears the finished state at the next system clock edge, and holds data drive off whether chip select is high or low.
- R3: The counter advances only on a detected rising serial-clock edge while output enable is high and chip select is low. Edges arriving while chip select is high leave the counter unchanged.
- R4: Bits leave in ascending address order. The bit at address 0 comes first, and each counted edge presents the bit at the next address.
- R5: The data drive-enable is high exactly when output enable is high, chip select is low, and the last bit has not yet been shifted out.
- R6: The counted edge that consumes the bit at address DEPTH-1 ends the stream. The cascade output goes low and data drive goes off. The counter does not wrap, and further edges change nothing until output enable goes low.
- R7: With the stream finished, chip select high returns the cascade output high, and chip select low again pulls it low.
- R8: A write with the write enable high stores the write data at the write address on a system clock edge, and that value is what the readout later shows at that address.
- R9: A serial clock held high for many system clock cycles counts as a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial clock is sampled on it |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| dclk_i | input | 1 | Serial clock from the host |
| oe_i | input | 1 | Output enable (high) / counter clear (low) |
| cs_n_i | input | 1 | Chip select, active low |
| wr_en_i | input | 1 | Preload write enable |
| wr_addr_i | input | AW | Preload bit address |
| wr_data_i | input | 1 | Preload bit value |
| data_o | output | 1 | Serial data value for the pad |
| data_oe_o | output | 1 | Pad drive enable; low means high-impedance |
| cascade_n_o | output | 1 | Cascade select to the next device, active low |

## Verification
The bench aims at the end of the stream. It clocks past the last bit and checks that a design which wraps instead of stopping fails: such a design would show bit 0 again and keep driving the shared line. It also checks that a design asserting cascade one bit early loses the final bit. Edges arriving while chip select is high must leave the counter unchanged; a design that ignored select would skip bits. A clear issued with select still low must stop data drive, and a serial clock held high must count once, since a level-triggered counter would run through many addresses.

// File: rtl/scr_pkg.sv
package scr_pkg;

  typedef struct packed {
    logic clear;
    logic step;
    logic drive;
    logic casc;
  } scr_ctrl_t;

  function automatic scr_ctrl_t scr_decode(input logic oe, input logic cs_n,
                                           input logic rise, input logic done);
    scr_ctrl_t c;
    c.clear = ~oe;
    c.step  = rise & oe & ~cs_n & ~done;
    c.drive = oe & ~cs_n & ~done;
    c.casc  = done & ~cs_n;
    return c;
  endfunction

endpackage

// File: rtl/scr_reset_sync.sv
module scr_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/scr_rise_detect.sv
module scr_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  // Reset to high so a level already high at release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/scr_bit_store.sv
module scr_bit_store #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_data_o
);
  logic [DEPTH-1:0] bits_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_bit
    logic sel;
    assign sel = wr_en_i && (wr_addr_i == AW'(i));
    always_ff @(posedge clk) begin
      if (sel) bits_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = bits_q[rd_addr_i];
endmodule

// File: rtl/scr_addr_ctrl.sv
module scr_addr_ctrl #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q, addr_d;
  logic          done_q, done_d;
  logic          upd;

  always_comb begin
    addr_d = addr_q;
    done_d = done_q;
    if (clear_i) begin
      addr_d = '0;
      done_d = 1'b0;
    end else if (step_i) begin
      if (addr_q == LAST) done_d = 1'b1;
      else                addr_d = addr_q + 1'b1;
    end
  end

  assign upd = clear_i | step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (upd) begin
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;
endmodule

// File: rtl/scr_reader.sv
module scr_reader
  import scr_pkg::*;
#(
  parameter  int unsigned DEPTH = 256,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dclk_i,
  input  logic          oe_i,
  input  logic          cs_n_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_data_i,
  output logic          data_o,
  output logic          data_oe_o,
  output logic          cascade_n_o
);
  logic          rst_sync_n;
  logic          dclk_rise;
  logic [AW-1:0] addr_q;
  logic          done_q;
  scr_ctrl_t     ctrl;

  scr_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  scr_rise_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lvl_i  (dclk_i),
    .rise_o (dclk_rise)
  );

  assign ctrl = scr_decode(oe_i, cs_n_i, dclk_rise, done_q);

  scr_addr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear_i (ctrl.clear),
    .step_i  (ctrl.step),
    .addr_o  (addr_q),
    .done_o  (done_q)
  );

  scr_bit_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk       (clk),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (addr_q),
    .rd_data_o (data_o)
  );

  assign data_oe_o   = ctrl.drive;
  assign cascade_n_o = ~ctrl.casc;
endmodule

// File: rtl/scr_reader_chk.sv
module scr_reader_chk #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          oe_i,
  input logic          cs_n_i,
  input logic          dclk_rise,
  input logic          data_oe_o,
  input logic          cascade_n_o,
  input logic [AW-1:0] addr_q,
  input logic          done_q
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !oe_i |=> (addr_q == '0 && !done_q));

  assert_hold_unselected_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oe_i && (cs_n_i || !dclk_rise)) |=> ($stable(addr_q) && $stable(done_q)));

  assert_step_next_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dclk_rise && oe_i && !cs_n_i && !done_q && addr_q != LAST)
      |=> (addr_q == AW'($past(addr_q) + 1'b1)));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_q && oe_i) |=> (done_q && addr_q == LAST));

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_oe_o |-> cascade_n_o);

  assert_deselect_cascade_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cs_n_i |-> cascade_n_o);
endmodule

bind scr_reader scr_reader_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .oe_i        (oe_i),
  .cs_n_i      (cs_n_i),
  .dclk_rise   (dclk_rise),
  .data_oe_o   (data_oe_o),
  .cascade_n_o (cascade_n_o),
  .addr_q      (addr_q),
  .done_q      (done_q)
);

// File: tb/scr_reader_bench.sv
module scr_reader_bench;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned AW    = 4;

  logic clk = 1'b0;
  logic rst_n, dclk, oe, cs_n, wr_en, wr_data;
  logic [AW-1:0] wr_addr;
  logic data, data_oe, casc_n;
  logic [DEPTH-1:0] pat;
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  scr_reader #(.DEPTH(DEPTH)) u_scr_reader (
    .clk(clk), .rst_n(rst_n), .dclk_i(dclk), .oe_i(oe), .cs_n_i(cs_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .data_o(data), .data_oe_o(data_oe), .cascade_n_o(casc_n)
  );

  typedef struct packed {
    logic       oe;
    logic       cs_n;
    logic       pulse;
    logic [7:0] idx;
    logic       doe;
    logic       casc_n;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, 1'b0, 8'd0, 1'b1, 1'b1},  // R1 first bit
    '{1'b1, 1'b0, 1'b1, 8'd1, 1'b1, 1'b1},  // R4 next bit
    '{1'b1, 1'b0, 1'b1, 8'd2, 1'b1, 1'b1},  // R4
    '{1'b1, 1'b1, 1'b1, 8'd2, 1'b0, 1'b1},  // R3 edge while deselected
    '{1'b1, 1'b0, 1'b0, 8'd2, 1'b1, 1'b1},  // R3 counter kept
    '{1'b0, 1'b0, 1'b1, 8'd0, 1'b0, 1'b1},  // R2 clear, select low
    '{1'b1, 1'b0, 1'b0, 8'd0, 1'b1, 1'b1},  // R2 restarted at bit 0
    '{1'b1, 1'b0, 1'b1, 8'd1, 1'b1, 1'b1}   // R4
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int idx, input logic doe, input logic cn);
    chk({req, " drive"}, int'(data_oe), int'(doe));
    chk({req, " cascade"}, int'(casc_n), int'(cn));
    if (doe) chk({req, " data"}, int'(data), int'(pat[idx]));
  endtask

  task automatic pulse();
    @(negedge clk) dclk = 1'b1;
    @(negedge clk) dclk = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) pat[i] = (((i * 7) + 3) % 5) < 2;
    rst_n = 1'b0; dclk = 1'b0; oe = 1'b0; cs_n = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R8 preload
    for (int i = 0; i < DEPTH; i++) begin
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = pat[i];
      @(negedge clk);
    end
    wr_en = 1'b0;
    @(negedge clk);
    // R1 reset state with output enable low
    chk_state("R1 reset", 0, 1'b0, 1'b1);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      oe = VT[v].oe; cs_n = VT[v].cs_n;
      if (VT[v].pulse) pulse();
      @(negedge clk);
      chk_state($sformatf("R3/R4 vector %0d", v), int'(VT[v].idx), VT[v].doe, VT[v].casc_n);
    end

    // R4 walk to the last bit, R5 drive held
    for (int i = 2; i < DEPTH; i++) begin
      pulse();
      @(negedge clk);
      chk_state("R4 ascending", i, 1'b1, 1'b1);
    end
    // R6 consume last bit
    pulse();
    @(negedge clk);
    chk_state("R6 end of data", 0, 1'b0, 1'b0);
    pulse(); pulse();
    @(negedge clk);
    chk_state("R6 no wrap", 0, 1'b0, 1'b0);
    // R7 select release and reselect
    cs_n = 1'b1;
    @(negedge clk);
    chk_state("R7 deselect", 0, 1'b0, 1'b1);
    cs_n = 1'b0;
    @(negedge clk);
    chk_state("R7 reselect", 0, 1'b0, 1'b0);
    // R2 clear after finish
    oe = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk_state("R2 clear after end", 0, 1'b0, 1'b1);
    oe = 1'b1;
    @(negedge clk);
    chk_state("R5 drive resumes", 0, 1'b1, 1'b1);
    // R9 held serial clock
    dclk = 1'b1;
    repeat (6) @(negedge clk);
    dclk = 1'b0;
    @(negedge clk);
    chk_state("R9 held level", 1, 1'b1, 1'b1);
    // R8 rewrite one bit and read it back
    wr_en = 1'b1; wr_addr = AW'(1); wr_data = ~pat[1];
    @(negedge clk);
    wr_en = 1'b0;
    pat[1] = ~pat[1];
    @(negedge clk);
    chk_state("R8 rewritten bit", 1, 1'b1, 1'b1);
    // R1 power-on reset mid-stream
    pulse(); pulse();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_state("R1 reset mid-stream", 0, 1'b1, 1'b1);
    finish_run();
  end
endmodule